// File: doc/BRIEF.md
# Dock Instruction Ring

This block is the instruction queue of one dock. Instructions arrive from the switch fabric at the insertion point through a valid/ready handshake and go into a circular store of configurable depth. The oldest entry sits at the execution point and is offered to an external execution datapath. That datapath is not part of this block. It pulses a completion strobe when it has finished with the offered instruction.

The ring handles the queue-control instructions itself. A kill waits at the insertion point and removes consecutive instructions from the execution point. A clog stops execution for as long as it sits at the head. An unclog waits until a clog is at the head, and then both retire. When the datapath reports completion, the ring applies the count rules to the head instruction. Depending on its count and flags, the instruction is dropped, run again in place, or moved to the tail with a smaller count. A count of all ones marks a standing instruction, which never runs out.

Top module: `dock_ring`

## Requirements
- R1: Instructions are 26 bits wide and are classified by their upper bits. Bit 25 = 1 is a normal instruction, and bits [25:24] = 01 is a literal. Bits [25:21] = 00101 is a kill, 00100 is a clog and 00010 is an unclog. Every other pattern with bits [25:24] = 00 is reserved: it is accepted and then discarded without being stored. The 7-bit count is in bits [6:0]. The requeue flag of a normal instruction is bit 18.
- R2: Stored instructions (normal, literal and clog) reach the execution point in arrival order. `exec_valid` is high exactly when the head is a normal or literal instruction and no kill is waiting, and `exec_instr` shows the head.
- R3: When completion is reported for a head instruction whose count is 0, that instruction is removed from the ring.
- R4: When completion is reported for a normal instruction with bit 18 = 0 and a nonzero count, the instruction stays at the execution point and its count is decremented.
- R5: When completion is reported for an instruction with a nonzero count that is a literal, or a normal instruction with bit 18 = 1, the instruction moves to the tail of the ring with its count decremented.
- R6: A count of 127 is never decremented, so such an instruction is repeated or requeued indefinitely.
- R7: A kill with count n is accepted and then waits. While it waits, `in_ready` and `exec_valid` are low. It removes one head instruction per cycle whenever the head is not a clog, and it retires after removing n+1 instructions.
- R8: A clog at the head keeps `exec_valid` low and ignores `exec_done`. The instructions behind it stay in the ring.
- R9: An accepted unclog blocks further input until a clog is at the head. In that cycle the clog is removed and the unclog retires.
- R10: A normal, literal or clog instruction is refused while the ring is full. Kill, unclog and reserved words are still accepted when the ring is full. A requeue in a full ring is never lost.
- R11: Reset empties the ring and cancels any waiting kill or unclog. An `exec_done` pulse while `exec_valid` is low, including when the ring is empty, has no effect.
- R12: `occupancy` gives the number of stored instructions (0 to DEPTH), and `empty` is high when that number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming instruction present |
| in_instr | input | 26 | Incoming instruction |
| in_ready | output | 1 | Incoming instruction is taken this cycle |
| exec_valid | output | 1 | Head instruction offered to the datapath |
| exec_instr | output | 26 | Head instruction |
| exec_done | input | 1 | Datapath finished the offered instruction |
| occupancy | output | $clog2(DEPTH+1) | Number of stored instructions |
| empty | output | 1 | Ring holds no instruction |

## Verification
The checker assumes that the fabric side keeps `in_valid` high and `in_instr` unchanged while `in_ready` is low. The bench's single sending task always holds its word until the word is taken, so this assumption is met. The properties tied to completion only look at cycles where `exec_valid` is high and no new word is being taken, because a word taken in the same cycle would change the occupancy. The bench also pulses `exec_done` while a clog is at the head and while the ring is empty, to show that these pulses are ignored. Two stalls (a kill arriving at an empty ring, and a kill waiting behind a clog) can only be cleared by reset, so the bench uses reset to end those scenarios.

// File: rtl/dock_ring_pkg.sv
package dock_ring_pkg;
  localparam int unsigned INSTR_W = 26;
  localparam int unsigned CNT_W   = 7;
  localparam int unsigned RQ_POS  = 18;
  localparam logic [CNT_W-1:0] CNT_FOREVER = '1;

  typedef enum logic [2:0] {
    K_NORMAL,
    K_LITERAL,
    K_CLOG,
    K_UNCLOG,
    K_KILL,
    K_RESERVED
  } kind_e;
endpackage

// File: rtl/dock_ring_decode.sv
module dock_ring_decode
  import dock_ring_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output kind_e              kind
);
  always_comb begin
    if (instr[25]) begin
      kind = K_NORMAL;
    end else if (instr[24]) begin
      kind = K_LITERAL;
    end else begin
      case (instr[23:21])
        3'b101:  kind = K_KILL;
        3'b100:  kind = K_CLOG;
        3'b010:  kind = K_UNCLOG;
        default: kind = K_RESERVED;
      endcase
    end
  end
endmodule

// File: rtl/dock_ring_count.sv
module dock_ring_count
  import dock_ring_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  kind_e              kind,
  output logic               discard,
  output logic               requeue,
  output logic [INSTR_W-1:0] next_instr
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt      = instr[CNT_W-1:0];
    discard  = (cnt == '0);
    requeue  = !discard && ((kind == K_LITERAL) || ((kind == K_NORMAL) && instr[RQ_POS]));
    cnt_next = (cnt == CNT_FOREVER) ? cnt : cnt - 1'b1;
    next_instr = {instr[INSTR_W-1:CNT_W], cnt_next};
  end
endmodule

// File: rtl/dock_ring_store.sv
module dock_ring_store #(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned W     = 26,
  localparam int unsigned OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          wr_rq,
  input  logic [W-1:0]  rq_data,
  input  logic          wr_in,
  input  logic [W-1:0]  in_data,
  input  logic          wr_head,
  input  logic [W-1:0]  head_new,
  output logic [W-1:0]  head_data,
  output logic [OW-1:0] occ,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic [OW-1:0] occ_q, occ_d;
  logic [PW-1:0] in_idx;
  logic          ptr_en;
  logic [DEPTH-1:0][W-1:0] slots;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    in_idx = wr_rq ? step(tail_q) : tail_q;
    tail_d = tail_q;
    if (wr_rq) tail_d = step(tail_d);
    if (wr_in) tail_d = step(tail_d);
    head_d = pop ? step(head_q) : head_q;
    occ_d  = occ_q + OW'(wr_rq) + OW'(wr_in) - OW'(pop);
    ptr_en = pop | wr_rq | wr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    logic [W-1:0] d;
    logic         we;

    always_comb begin
      we = 1'b0;
      d  = q;
      if (wr_rq && (tail_q == PW'(g))) begin
        we = 1'b1;
        d  = rq_data;
      end else if (wr_in && (in_idx == PW'(g))) begin
        we = 1'b1;
        d  = in_data;
      end else if (wr_head && (head_q == PW'(g))) begin
        we = 1'b1;
        d  = head_new;
      end
    end

    always_ff @(posedge clk) begin
      if (we) q <= d;
    end

    assign slots[g] = q;
  end

  assign head_data = slots[head_q];
  assign occ       = occ_q;
  assign full      = (occ_q == OW'(DEPTH));
  assign empty     = (occ_q == '0);
endmodule

// File: rtl/dock_ring.sv
module dock_ring
  import dock_ring_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned OW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  output logic               exec_valid,
  output logic [INSTR_W-1:0] exec_instr,
  input  logic               exec_done,
  output logic [OW-1:0]      occupancy,
  output logic               empty
);
  kind_e              in_kind;
  kind_e              head_kind;
  logic [INSTR_W-1:0] head_data;
  logic               full;
  logic               ring_empty;
  logic [OW-1:0]      occ;

  logic               discard;
  logic               requeue;
  logic [INSTR_W-1:0] next_instr;

  logic               kill_pend_q, kill_pend_d;
  logic [CNT_W-1:0]   kill_cnt_q,  kill_cnt_d;
  logic               unclog_pend_q, unclog_pend_d;
  logic               pend_en;

  logic in_stores, in_fire;
  logic head_clog, head_exec;
  logic unclog_hit, kill_hit, done;
  logic pop, wr_rq, wr_in, wr_head;

  dock_ring_decode u_dec_in   (.instr(in_instr),  .kind(in_kind));
  dock_ring_decode u_dec_head (.instr(head_data), .kind(head_kind));

  dock_ring_count u_count (
    .instr      (head_data),
    .kind       (head_kind),
    .discard    (discard),
    .requeue    (requeue),
    .next_instr (next_instr)
  );

  dock_ring_store #(.DEPTH(DEPTH), .W(INSTR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .wr_rq     (wr_rq),
    .rq_data   (next_instr),
    .wr_in     (wr_in),
    .in_data   (in_instr),
    .wr_head   (wr_head),
    .head_new  (next_instr),
    .head_data (head_data),
    .occ       (occ),
    .full      (full),
    .empty     (ring_empty)
  );

  always_comb begin
    in_stores  = (in_kind == K_NORMAL) || (in_kind == K_LITERAL) || (in_kind == K_CLOG);
    in_ready   = !kill_pend_q && !unclog_pend_q && (!full || !in_stores);
    in_fire    = in_valid && in_ready;

    head_clog  = !ring_empty && (head_kind == K_CLOG);
    head_exec  = !ring_empty && ((head_kind == K_NORMAL) || (head_kind == K_LITERAL));
    exec_valid = head_exec && !kill_pend_q;

    unclog_hit = unclog_pend_q && head_clog;
    kill_hit   = kill_pend_q && head_exec;
    done       = exec_done && exec_valid;

    pop     = unclog_hit || kill_hit || (done && (discard || requeue));
    wr_rq   = done && requeue;
    wr_head = done && !discard && !requeue;
    wr_in   = in_fire && in_stores;
  end

  always_comb begin
    kill_pend_d   = kill_pend_q;
    kill_cnt_d    = kill_cnt_q;
    unclog_pend_d = unclog_pend_q;
    if (in_fire && (in_kind == K_KILL)) begin
      kill_pend_d = 1'b1;
      kill_cnt_d  = in_instr[CNT_W-1:0];
    end else if (kill_hit) begin
      if (kill_cnt_q == '0) kill_pend_d = 1'b0;
      else                  kill_cnt_d  = kill_cnt_q - 1'b1;
    end
    if (in_fire && (in_kind == K_UNCLOG)) unclog_pend_d = 1'b1;
    else if (unclog_hit)                  unclog_pend_d = 1'b0;
    pend_en = in_fire || kill_hit || unclog_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_pend_q   <= 1'b0;
      kill_cnt_q    <= '0;
      unclog_pend_q <= 1'b0;
    end else if (pend_en) begin
      kill_pend_q   <= kill_pend_d;
      kill_cnt_q    <= kill_cnt_d;
      unclog_pend_q <= unclog_pend_d;
    end
  end

  assign exec_instr = head_data;
  assign occupancy  = occ;
  assign empty      = ring_empty;
endmodule

// File: rtl/dock_ring_chk.sv
module dock_ring_chk #(
  parameter  int unsigned DEPTH = 8,
  localparam int unsigned OW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [25:0]   in_instr,
  input logic          in_ready,
  input logic          exec_valid,
  input logic [25:0]   exec_instr,
  input logic          exec_done,
  input logic [OW-1:0] occupancy,
  input logic          empty
);
  logic taking;
  logic finishing;
  assign taking    = in_valid && in_ready;
  assign finishing = exec_valid && exec_done;

  // Input assumption: a refused word is held unchanged (R10)
  p_hold_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_instr)));

  p_occ_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= int'(DEPTH));

  p_occ_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int'(occupancy) <= int'($past(occupancy)) + 1) &&
              (int'(occupancy) + 1 >= int'($past(occupancy)))));

  p_empty_no_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !exec_valid);

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && (exec_instr[6:0] == 7'd0) && !taking) |=>
      (int'(occupancy) + 1 == int'($past(occupancy))));

  p_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && (exec_instr[6:0] != 7'd0)) |=>
      (int'(occupancy) >= int'($past(occupancy))));

  p_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && exec_instr[25] && !exec_instr[18] && !taking &&
     (exec_instr[6:0] != 7'd0) && (exec_instr[6:0] != 7'd127)) |=>
      (exec_valid && (exec_instr[6:0] == $past(exec_instr[6:0]) - 7'd1)));

  p_standing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && exec_instr[25] && !exec_instr[18] && !taking &&
     (exec_instr[6:0] == 7'd127)) |=>
      (exec_valid && (exec_instr == $past(exec_instr))));
endmodule

bind dock_ring dock_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_instr   (in_instr),
  .in_ready   (in_ready),
  .exec_valid (exec_valid),
  .exec_instr (exec_instr),
  .exec_done  (exec_done),
  .occupancy  (occupancy),
  .empty      (empty)
);

// File: tb/dock_ring_bench.sv
module dock_ring_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int OW         = $clog2(DEPTH + 1);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [25:0]   in_instr;
  logic          in_ready;
  logic          exec_valid;
  logic [25:0]   exec_instr;
  logic          exec_done;
  logic [OW-1:0] occupancy;
  logic          empty;

  int n_chk = 0;
  int n_bad = 0;

  dock_ring #(.DEPTH(DEPTH)) u_dock_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .in_ready   (in_ready),
    .exec_valid (exec_valid),
    .exec_instr (exec_instr),
    .exec_done  (exec_done),
    .occupancy  (occupancy),
    .empty      (empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [25:0] f_norm(input logic rq, input logic [10:0] dest, input logic [6:0] c);
    return {1'b1, 6'b0, rq, dest, c};
  endfunction
  function automatic logic [25:0] f_lit(input logic [16:0] v, input logic [6:0] c);
    return {2'b01, v, c};
  endfunction
  function automatic logic [25:0] f_kill(input logic [6:0] c);
    return {5'b00101, 14'b0, c};
  endfunction
  localparam logic [25:0] W_CLOG   = {5'b00100, 21'b0};
  localparam logic [25:0] W_UNCLOG = {5'b00010, 21'b0};
  localparam logic [25:0] W_RSV    = {5'b00000, 21'h5};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_instr  = '0;
    exec_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [25:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    exec_done = 1'b1;
    @(posedge clk);
    #1;
    exec_done = 1'b0;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R11", "occupancy after reset", 32'(occupancy), 0);
    chk_eq("R12", "empty after reset", 32'(empty), 1);
    chk_eq("R11", "in_ready after reset", 32'(in_ready), 1);
    chk_eq("R2", "exec_valid after reset", 32'(exec_valid), 0);
  endtask

  task automatic t_order();
    send(f_norm(1'b0, 11'd1, 7'd0));
    send(f_norm(1'b0, 11'd2, 7'd0));
    look();
    chk_eq("R12", "occupancy two stored", 32'(occupancy), 2);
    chk_eq("R2", "exec_valid with head", 32'(exec_valid), 1);
    chk_eq("R2", "first head", 32'(exec_instr), 32'(f_norm(1'b0, 11'd1, 7'd0)));
    strobe(); look();
    chk_eq("R3", "occupancy after discard", 32'(occupancy), 1);
    chk_eq("R2", "second head", 32'(exec_instr), 32'(f_norm(1'b0, 11'd2, 7'd0)));
    strobe(); look();
    chk_eq("R12", "empty after both", 32'(empty), 1);
  endtask

  task automatic t_repeat();
    send(f_norm(1'b0, 11'd3, 7'd2));
    strobe(); look();
    chk_eq("R4", "repeat count 1", 32'(exec_instr), 32'(f_norm(1'b0, 11'd3, 7'd1)));
    chk_eq("R4", "repeat stays", 32'(occupancy), 1);
    strobe(); look();
    chk_eq("R4", "repeat count 0", 32'(exec_instr), 32'(f_norm(1'b0, 11'd3, 7'd0)));
    strobe(); look();
    chk_eq("R3", "repeat ends", 32'(empty), 1);
  endtask

  task automatic t_requeue(input logic [25:0] first, input logic [25:0] first_after, input string req);
    send(first);
    send(f_norm(1'b0, 11'd5, 7'd0));
    strobe(); look();
    chk_eq(req, "requeued behind", 32'(exec_instr), 32'(f_norm(1'b0, 11'd5, 7'd0)));
    chk_eq(req, "requeue keeps occupancy", 32'(occupancy), 2);
    strobe(); look();
    chk_eq(req, "requeued at head", 32'(exec_instr), 32'(first_after));
    strobe(); look();
    chk_eq("R3", "requeue drained", 32'(empty), 1);
  endtask

  task automatic t_standing();
    send(f_norm(1'b0, 11'd6, 7'd127));
    repeat (3) strobe();
    look();
    chk_eq("R6", "standing unchanged", 32'(exec_instr), 32'(f_norm(1'b0, 11'd6, 7'd127)));
    chk_eq("R6", "standing stays", 32'(occupancy), 1);
    send(f_kill(7'd0));
    look();
    chk_eq("R7", "kill blocks input", 32'(in_ready), 0);
    chk_eq("R7", "kill hides head", 32'(exec_valid), 0);
    look();
    chk_eq("R7", "kill removed standing", 32'(occupancy), 0);
    chk_eq("R7", "kill retired", 32'(in_ready), 1);
  endtask

  task automatic t_kill();
    for (int i = 0; i < 4; i++) send(f_norm(1'b0, 11'(10 + i), 7'd0));
    send(f_kill(7'd1));
    look();
    chk_eq("R7", "kill waiting occupancy", 32'(occupancy), 4);
    look();
    chk_eq("R7", "kill first removal", 32'(occupancy), 3);
    look();
    chk_eq("R7", "kill removes n+1", 32'(occupancy), 2);
    chk_eq("R7", "head after kill", 32'(exec_instr), 32'(f_norm(1'b0, 11'd12, 7'd0)));
    chk_eq("R7", "input free after kill", 32'(in_ready), 1);
    strobe(); strobe(); look();
    chk_eq("R12", "kill test drained", 32'(empty), 1);
  endtask

  task automatic t_clog();
    send(W_CLOG);
    send(f_norm(1'b0, 11'd20, 7'd0));
    look();
    chk_eq("R8", "clog hides head", 32'(exec_valid), 0);
    strobe(); look();
    chk_eq("R8", "done ignored under clog", 32'(occupancy), 2);
    send(W_UNCLOG);
    look();
    chk_eq("R9", "unclog blocks input", 32'(in_ready), 0);
    look();
    chk_eq("R9", "clog removed", 32'(occupancy), 1);
    chk_eq("R9", "head after unclog", 32'(exec_instr), 32'(f_norm(1'b0, 11'd20, 7'd0)));
    chk_eq("R9", "execution resumes", 32'(exec_valid), 1);
    strobe(); look();
    chk_eq("R12", "clog test drained", 32'(empty), 1);
  endtask

  task automatic t_unclog_wait();
    send(f_norm(1'b0, 11'd21, 7'd0));
    send(W_CLOG);
    send(W_UNCLOG);
    look();
    chk_eq("R9", "unclog waits, head runs", 32'(exec_valid), 1);
    chk_eq("R9", "unclog waits occupancy", 32'(occupancy), 2);
    strobe(); look();
    chk_eq("R9", "clog reached head", 32'(occupancy), 1);
    look();
    chk_eq("R9", "unclog and clog retired", 32'(occupancy), 0);
    chk_eq("R9", "input free after unclog", 32'(in_ready), 1);
  endtask

  task automatic t_full_requeue();
    do_reset();
    send(f_norm(1'b1, 11'd30, 7'd1));
    for (int i = 1; i < DEPTH; i++) send(f_norm(1'b0, 11'(30 + i), 7'd0));
    look();
    chk_eq("R12", "ring full", 32'(occupancy), DEPTH);
    in_instr = f_norm(1'b0, 11'd99, 7'd0);
    #1;
    chk_eq("R10", "store refused when full", 32'(in_ready), 0);
    in_instr = W_RSV;
    #1;
    chk_eq("R10", "reserved accepted when full", 32'(in_ready), 1);
    strobe(); look();
    chk_eq("R10", "requeue in full ring kept", 32'(occupancy), DEPTH);
    chk_eq("R5", "next head", 32'(exec_instr), 32'(f_norm(1'b0, 11'd31, 7'd0)));
    for (int i = 1; i < DEPTH; i++) strobe();
    look();
    chk_eq("R5", "requeued word at head", 32'(exec_instr), 32'(f_norm(1'b1, 11'd30, 7'd0)));
    strobe(); look();
    chk_eq("R12", "full test drained", 32'(empty), 1);
  endtask

  task automatic t_full_unclog();
    do_reset();
    send(W_CLOG);
    for (int i = 1; i < DEPTH; i++) send(f_norm(1'b0, 11'(40 + i), 7'd0));
    look();
    in_instr = f_norm(1'b0, 11'd99, 7'd0);
    #1;
    chk_eq("R10", "normal refused full", 32'(in_ready), 0);
    send(W_UNCLOG);
    look();
    look();
    chk_eq("R10", "unclog accepted when full", 32'(occupancy), DEPTH - 1);
    chk_eq("R9", "first normal at head", 32'(exec_instr), 32'(f_norm(1'b0, 11'd41, 7'd0)));
  endtask

  task automatic t_reserved();
    do_reset();
    send(W_RSV);
    look();
    chk_eq("R1", "reserved not stored", 32'(occupancy), 0);
    chk_eq("R1", "reserved leaves input open", 32'(in_ready), 1);
    strobe(); look();
    chk_eq("R11", "done on empty ring", 32'(occupancy), 0);
    chk_eq("R11", "nothing offered", 32'(exec_valid), 0);
  endtask

  task automatic t_kill_empty();
    send(f_kill(7'd0));
    repeat (3) look();
    chk_eq("R7", "kill on empty waits", 32'(in_ready), 0);
    do_reset();
    chk_eq("R11", "reset cancels kill", 32'(in_ready), 1);
    send(f_norm(1'b0, 11'd50, 7'd0));
    look();
    chk_eq("R11", "head offered after reset", 32'(exec_valid), 1);
    strobe();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_order();
    t_repeat();
    t_requeue(f_norm(1'b1, 11'd4, 7'd1), f_norm(1'b1, 11'd4, 7'd0), "R5");
    t_requeue(f_lit(17'h1abcd, 7'd1), f_lit(17'h1abcd, 7'd0), "R5");
    t_standing();
    t_kill();
    t_clog();
    t_unclog_wait();
    t_full_requeue();
    t_full_unclog();
    t_reserved();
    t_kill_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule